// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a word-wide flash array and watches the write cycles that reach it. Each accepted write carries an address and a data word. The block matches the writes against the multi-write unlock sequences that guard every modifying command. When a sequence completes, it emits exactly one decoded operation together with its operands. The storage array and the timing engine that performs the operation lie downstream and take that operation as their input.

Every command opens with the same two keyed writes. The third write selects one of three things: a program, an identification-mode change, or a further keyed pair that leads to a sixth write choosing between chip erase, sector erase and boot-region lock. Only the low data byte and the low address bits take part in the match. A write that breaks a sequence returns the decoder to its idle state without producing anything. While the array engine reports busy, the decoder does not react to writes at all.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high reset drives op_valid low and clears any partly entered sequence, so writes that were accepted before the reset never complete a command afterwards.
- R2: Command keys are compared on data bits 7:0 only. Bits 15:8 of every command write have no effect on decoding.
- R3: Unlock addresses are compared on address bits 14:0 only. A write matches 0x5555 or 0x2AAA whatever its upper address bits hold.
- R4: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 followed by any fourth write produce a program operation. Its op_addr and op_data are the full address and full data word of that fourth write.
- R5: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10 produce a chip-erase operation.
- R6: The same five opening writes followed by a sixth write with data 0x30 at any address produce a sector-erase operation. Its op_addr is the address of that sixth write.
- R7: The same five opening writes followed by 0x5555/0x40 produce a boot-lock operation.
- R8: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 produce an identification-entry operation.
- R9: An identification-exit operation is produced by either of two inputs: the three writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xF0, or a single write with data 0xF0 to any address while the decoder is idle.
- R10: A write that does not match the next expected address/data returns the decoder to idle and produces no operation. Later writes must restart the sequence from its first write.
- R11: A write presented while busy is high produces no operation and leaves the sequence position unchanged.
- R12: An operation appears as op_valid high for exactly the one cycle after the clock edge that accepted its final write. The op_code values are 1 program, 2 chip erase, 3 sector erase, 4 boot lock, 5 identification entry, 6 identification exit. op_addr and op_data hold that final write's address and data.
- R13: Cycles with wr_valid low between the writes of a sequence do not disturb its progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A qualified bus write is present this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data word of the write |
| busy | input | 1 | Array engine is programming or erasing; writes are ignored |
| op_valid | output | 1 | One-cycle pulse marking a decoded operation |
| op_code | output | 3 | Decoded operation code (see R12) |
| op_addr | output | ADDR_W | Address operand of the operation |
| op_data | output | DATA_W | Data operand of the operation |

## Verification
Each decoded operation is due exactly one cycle after the edge that accepts the last write of its sequence. Writes that do not complete a sequence produce nothing at all. The bench therefore presents every write at a falling edge and lets one rising edge pass. It then compares all four result ports at the next falling edge, before the following write goes in. That same sample is also where the absence of an operation is confirmed after aborted sequences, busy writes and reset. The gap test stretches the sequence with idle cycles to show that only accepted writes advance it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_KEY1,
    S_KEY2,
    S_PROG,
    S_EXT3,
    S_EXT4,
    S_EXT5
  } seq_state_e;

  localparam logic [2:0] OPC_NONE    = 3'd0;
  localparam logic [2:0] OPC_PROGRAM = 3'd1;
  localparam logic [2:0] OPC_CHIP    = 3'd2;
  localparam logic [2:0] OPC_SECTOR  = 3'd3;
  localparam logic [2:0] OPC_LOCK    = 3'd4;
  localparam logic [2:0] OPC_ID_ON   = 3'd5;
  localparam logic [2:0] OPC_ID_OFF  = 3'd6;

  localparam logic [7:0] KEY_AA = 8'hAA;
  localparam logic [7:0] KEY_55 = 8'h55;
  localparam logic [7:0] KEY_A0 = 8'hA0;
  localparam logic [7:0] KEY_80 = 8'h80;
  localparam logic [7:0] KEY_90 = 8'h90;
  localparam logic [7:0] KEY_F0 = 8'hF0;
  localparam logic [7:0] KEY_10 = 8'h10;
  localparam logic [7:0] KEY_30 = 8'h30;
  localparam logic [7:0] KEY_40 = 8'h40;

  typedef struct packed {
    logic at_a1;
    logic at_a2;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_f0;
    logic d_10;
    logic d_30;
    logic d_40;
  } hit_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int              CMP_W     = 15,
  parameter logic [CMP_W-1:0] UNLOCK_A1 = 'h5555,
  parameter logic [CMP_W-1:0] UNLOCK_A2 = 'h2AAA
) (
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [7:0]       key,
  output hit_t             hit
);

  always_comb begin
    hit.at_a1 = (addr_lo == UNLOCK_A1);
    hit.at_a2 = (addr_lo == UNLOCK_A2);
    hit.d_aa  = (key == KEY_AA);
    hit.d_55  = (key == KEY_55);
    hit.d_a0  = (key == KEY_A0);
    hit.d_80  = (key == KEY_80);
    hit.d_90  = (key == KEY_90);
    hit.d_f0  = (key == KEY_F0);
    hit.d_10  = (key == KEY_10);
    hit.d_30  = (key == KEY_30);
    hit.d_40  = (key == KEY_40);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  hit_t       hit,
  output logic       emit,
  output logic [2:0] emit_code
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    emit      = 1'b0;
    emit_code = OPC_NONE;
    if (accept) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: begin
          if (hit.at_a1 && hit.d_aa) begin
            state_d = S_KEY1;
          end else if (hit.d_f0) begin
            emit      = 1'b1;
            emit_code = OPC_ID_OFF;
          end
        end
        S_KEY1: begin
          if (hit.at_a2 && hit.d_55) state_d = S_KEY2;
        end
        S_KEY2: begin
          if (hit.at_a1) begin
            if (hit.d_a0) begin
              state_d = S_PROG;
            end else if (hit.d_80) begin
              state_d = S_EXT3;
            end else if (hit.d_90) begin
              emit      = 1'b1;
              emit_code = OPC_ID_ON;
            end else if (hit.d_f0) begin
              emit      = 1'b1;
              emit_code = OPC_ID_OFF;
            end
          end
        end
        S_PROG: begin
          emit      = 1'b1;
          emit_code = OPC_PROGRAM;
        end
        S_EXT3: begin
          if (hit.at_a1 && hit.d_aa) state_d = S_EXT4;
        end
        S_EXT4: begin
          if (hit.at_a2 && hit.d_55) state_d = S_EXT5;
        end
        S_EXT5: begin
          if (hit.d_30) begin
            emit      = 1'b1;
            emit_code = OPC_SECTOR;
          end else if (hit.at_a1 && hit.d_10) begin
            emit      = 1'b1;
            emit_code = OPC_CHIP;
          end else if (hit.at_a1 && hit.d_40) begin
            emit      = 1'b1;
            emit_code = OPC_LOCK;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/flash_cmd_outreg.sv
module flash_cmd_outreg #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [2:0]        emit_code,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_code  <= 3'd0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= emit;
      if (emit) begin
        op_code <= emit_code;
        op_addr <= in_addr;
        op_data <= in_data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W    = 18,
  parameter int               DATA_W    = 16,
  parameter int               CMP_W     = 15,
  parameter logic [CMP_W-1:0] UNLOCK_A1 = 'h5555,
  parameter logic [CMP_W-1:0] UNLOCK_A2 = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  localparam int KEY_W = 8;

  hit_t       hit;
  logic       accept;
  logic       emit;
  logic [2:0] emit_code;

  // A write counts only when the array engine is idle.
  assign accept = wr_valid && !busy;

  flash_cmd_match #(
    .CMP_W    (CMP_W),
    .UNLOCK_A1(UNLOCK_A1),
    .UNLOCK_A2(UNLOCK_A2)
  ) u_match (
    .addr_lo(wr_addr[CMP_W-1:0]),
    .key    (wr_data[KEY_W-1:0]),
    .hit    (hit)
  );

  flash_cmd_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .hit      (hit),
    .emit     (emit),
    .emit_code(emit_code)
  );

  flash_cmd_outreg #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .emit     (emit),
    .emit_code(emit_code),
    .in_addr  (wr_addr),
    .in_data  (wr_data),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W    = 18,
  parameter int               DATA_W    = 16,
  parameter int               CMP_W     = 15,
  parameter logic [CMP_W-1:0] UNLOCK_A1 = 'h5555
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_data
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !op_valid);

  p_op_follows_write_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> $past(wr_valid && !busy));

  p_code_legal_r12: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_code >= OPC_PROGRAM && op_code <= OPC_ID_OFF));

  p_prog_operands_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_PROGRAM) |->
      (op_addr == $past(wr_addr) && op_data == $past(wr_data)));

  p_chip_key_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_CHIP) |->
      (op_addr[CMP_W-1:0] == UNLOCK_A1 && op_data[7:0] == KEY_10));

  p_sector_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_SECTOR) |->
      (op_data[7:0] == KEY_30 && op_addr == $past(wr_addr)));

  p_lock_key_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_LOCK) |->
      (op_addr[CMP_W-1:0] == UNLOCK_A1 && op_data[7:0] == KEY_40));

  p_exit_key_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPC_ID_OFF) |-> (op_data[7:0] == KEY_F0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CMP_W    (CMP_W),
  .UNLOCK_A1(UNLOCK_A1)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_valid(wr_valid),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (busy),
  .op_valid(op_valid),
  .op_code (op_code),
  .op_addr (op_addr),
  .op_data (op_data)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  localparam int AW = 18;
  localparam int DW = 16;

  typedef struct packed {
    logic          v;
    logic          b;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ev;
    logic [2:0]    ec;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    logic [3:0]    rq;
  } vec_t;

  function automatic vec_t W(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] rq);
    return '{v:1'b1, b:1'b0, a:a, d:d, ev:1'b0, ec:3'd0, ea:'0, ed:'0, rq:rq};
  endfunction
  function automatic vec_t B(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] rq);
    return '{v:1'b1, b:1'b1, a:a, d:d, ev:1'b0, ec:3'd0, ea:'0, ed:'0, rq:rq};
  endfunction
  function automatic vec_t N(input logic [3:0] rq);
    return '{v:1'b0, b:1'b0, a:'0, d:'0, ev:1'b0, ec:3'd0, ea:'0, ed:'0, rq:rq};
  endfunction
  function automatic vec_t E(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [2:0] ec, input logic [3:0] rq);
    return '{v:1'b1, b:1'b0, a:a, d:d, ev:1'b1, ec:ec, ea:a, ed:d, rq:rq};
  endfunction

  localparam int NV = 55;
  localparam vec_t TBL [NV] = '{
    // R4 program
    W(18'h05555, 16'h00AA, 4), W(18'h02AAA, 16'h0055, 4), W(18'h05555, 16'h00A0, 4),
    E(18'h12345, 16'hBEEF, 3'd1, 4),
    // R2 upper data byte ignored
    W(18'h05555, 16'hFFAA, 2), W(18'h02AAA, 16'h3355, 2), W(18'h05555, 16'h12A0, 2),
    E(18'h00010, 16'h0F0F, 3'd1, 2),
    // R3 upper address bits ignored
    W(18'h25555, 16'h00AA, 3), W(18'h3AAAA, 16'h0055, 3), W(18'h15555, 16'h00A0, 3),
    E(18'h00001, 16'h1234, 3'd1, 3),
    // R5 chip erase
    W(18'h05555, 16'h00AA, 5), W(18'h02AAA, 16'h0055, 5), W(18'h05555, 16'h0080, 5),
    W(18'h05555, 16'h00AA, 5), W(18'h02AAA, 16'h0055, 5), E(18'h05555, 16'h0010, 3'd2, 5),
    // R6 sector erase
    W(18'h05555, 16'h00AA, 6), W(18'h02AAA, 16'h0055, 6), W(18'h05555, 16'h0080, 6),
    W(18'h05555, 16'h00AA, 6), W(18'h02AAA, 16'h0055, 6), E(18'h1F123, 16'h0030, 3'd3, 6),
    // R7 boot lock
    W(18'h05555, 16'h00AA, 7), W(18'h02AAA, 16'h0055, 7), W(18'h05555, 16'h0080, 7),
    W(18'h05555, 16'h00AA, 7), W(18'h02AAA, 16'h0055, 7), E(18'h05555, 16'h0040, 3'd4, 7),
    // R8 identification entry
    W(18'h05555, 16'h00AA, 8), W(18'h02AAA, 16'h0055, 8), E(18'h05555, 16'h0090, 3'd5, 8),
    // R9 identification exit, long and short forms
    W(18'h05555, 16'h00AA, 9), W(18'h02AAA, 16'h0055, 9), E(18'h05555, 16'h00F0, 3'd6, 9),
    E(18'h0ABCD, 16'h00F0, 3'd6, 9),
    // R10 mismatch in second write, then no restart
    W(18'h05555, 16'h00AA, 10), W(18'h02AAA, 16'h0056, 10), W(18'h05555, 16'h00A0, 10),
    W(18'h12345, 16'hBEEF, 10),
    // R10 mismatch in sixth write
    W(18'h05555, 16'h00AA, 10), W(18'h02AAA, 16'h0055, 10), W(18'h05555, 16'h0080, 10),
    W(18'h05555, 16'h00AA, 10), W(18'h02AAA, 16'h0055, 10), W(18'h05555, 16'h0020, 10),
    W(18'h00100, 16'h0030, 10),
    // R11 busy writes ignored, position kept
    W(18'h05555, 16'h00AA, 11), W(18'h02AAA, 16'h0055, 11), B(18'h05555, 16'h0090, 11),
    E(18'h05555, 16'h0090, 3'd5, 11),
    B(18'h00000, 16'h00F0, 11),
    // R12 single-cycle pulse
    E(18'h00000, 16'h00F0, 3'd6, 12), N(12)
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          op_valid;
  logic [2:0]    op_code;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic b, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid = v; busy = b; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic expect_op(input string tag, input logic [2:0] c,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(op_valid === 1'b1 && op_code === c && op_addr === a && op_data === d, tag, "op",
        {op_valid, op_code, 6'd0, op_addr, op_data}, {1'b1, c, 6'd0, a, d});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(op_valid === 1'b0, "R1", "op_valid in reset", 64'(op_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(op_valid === 1'b0 && op_code === 3'd0, "R1", "outputs after reset",
        {60'd0, op_valid, op_code}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].v, TBL[i].b, TBL[i].a, TBL[i].d);
      if (TBL[i].ev)
        expect_op($sformatf("R%0d row %0d", TBL[i].rq, i), TBL[i].ec, TBL[i].ea, TBL[i].ed);
      else
        chk(op_valid === 1'b0, $sformatf("R%0d row %0d", TBL[i].rq, i), "no op",
            64'(op_valid), 64'd0);
    end

    // R13: idle gaps inside a sequence
    cyc(1'b1, 1'b0, 18'h05555, 16'h00AA);
    repeat (3) cyc(1'b0, 1'b0, 18'h05555, 16'h0090);
    cyc(1'b1, 1'b0, 18'h02AAA, 16'h0055);
    repeat (2) cyc(1'b0, 1'b0, 18'h05555, 16'h0090);
    chk(op_valid === 1'b0, "R13", "no op during gaps", 64'(op_valid), 64'd0);
    cyc(1'b1, 1'b0, 18'h05555, 16'h0090);
    expect_op("R13", 3'd5, 18'h05555, 16'h0090);

    // R1: reset mid-sequence drops the partial unlock
    cyc(1'b1, 1'b0, 18'h05555, 16'h00AA);
    cyc(1'b1, 1'b0, 18'h02AAA, 16'h0055);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc(1'b1, 1'b0, 18'h05555, 16'h0090);
    chk(op_valid === 1'b0, "R1", "sequence cleared by reset", 64'(op_valid), 64'd0);

    // R12: back-to-back short exits give two pulses, then low
    cyc(1'b1, 1'b0, 18'h00002, 16'h00F0);
    expect_op("R12", 3'd6, 18'h00002, 16'h00F0);
    cyc(1'b1, 1'b0, 18'h00003, 16'h00F0);
    expect_op("R12", 3'd6, 18'h00003, 16'h00F0);
    cyc(1'b0, 1'b0, 18'h0, 16'h0);
    chk(op_valid === 1'b0, "R12", "pulse ends", 64'(op_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule